// File: doc/BRIEF.md
# Chip-Averaging Front-End Rounder

This block sits at the entry of a despreading datapath. It takes signed baseband samples on two parallel channels (in-phase and quadrature), arriving at two samples per chip. It reduces each sample stream to a 3-bit code per sample. In the normal mode, every accepted sample is added to the accepted sample before it. This gives a two-sample moving sum that spans one chip. The sum is halved and mapped to the nearest of eight half-unit levels, from -3.5 to +3.5.

A 3-bit code `c`, read as two's complement (-4 to 3), stands for the value `c + 0.5`. The halved sum of two integers is often an integer, and an integer lies exactly halfway between two such levels. A per-channel toggle resolves these ties, alternating between rounding down and rounding up, so the long-run rounding error averages to zero. A bypass control skips the averaging: the current sample alone is mapped to a level, using the same tie handling and clipping.

Each accepted sample yields one registered result per channel, one clock later. Results hold their value between accepted samples.

Top module: `fe_chip_avg`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and is low otherwise.
- R2: With `bypass` low, each channel's code is the level nearest to (x[n] + x[n-1]) / 2. When that sum is odd, the code is (sum - 1) / 2 exactly, where x[n-1] is the previous accepted sample of the same channel. Inputs are 4-bit two's complement; codes are 3-bit two's complement `c` meaning `c + 0.5`.
- R3: When the sum is even (a tie), the code alternates between sum/2 - 1 (down) and sum/2 (up). Each channel starts on "down" after reset, and every accepted tie flips that channel's direction.
- R4: A code beyond the range saturates: results above 3 give 3'b011, results below -4 give 3'b100.
- R5: With `bypass` high, the code comes from the current sample x alone: a tie between x - 1 and x, resolved by the same toggle as R3, with the saturation of R4. The accepted sample still becomes the previous sample.
- R6: A sample presented while `in_valid` is low is not taken as the previous sample and does not flip the tie direction.
- R7: The previous sample resets to zero, so the first accepted sample after reset is summed with 0.
- R8: Both codes hold their value in cycles when `out_valid` is low.
- R9: The two channels keep separate previous samples and separate tie directions.
- R10: During reset, `out_valid` is low and both codes are 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample pair on `i_in`/`q_in` is accepted this cycle |
| bypass | input | 1 | 1: quantize the current sample only; 0: two-sample averaging |
| i_in | input | IN_W (4) | In-phase sample, two's complement |
| q_in | input | IN_W (4) | Quadrature sample, two's complement |
| i_code | output | OUT_W (3) | In-phase level code (value = code + 0.5) |
| q_code | output | OUT_W (3) | Quadrature level code (value = code + 0.5) |
| out_valid | output | 1 | Codes were updated by the sample accepted one cycle earlier |

## Verification
Each code and `out_valid` change at the rising edge that accepts the sample, so they are due exactly one clock after the sample is driven. The driver applies a sample on a falling edge and queues the expected codes. The monitor compares them on the next falling edge, when the results have settled. On every falling edge where `out_valid` is low, the monitor checks that the codes still equal the last results. This covers R8, and it also exposes any effect of samples presented while `in_valid` was low.

// File: rtl/fe_avg_pkg.sv
package fe_avg_pkg;

   // Direction in which an exact midpoint between two levels is resolved.
   typedef enum logic {
      TIE_DOWN = 1'b0,
      TIE_UP   = 1'b1
   } tie_dir_e;

   // Number of parallel channels handled by the front end (I and Q).
   localparam int NUM_CH = 2;

   function automatic tie_dir_e tie_next(input tie_dir_e cur);
      return (cur == TIE_DOWN) ? TIE_UP : TIE_DOWN;
   endfunction

endpackage

// File: rtl/fe_pair_sum.sv
module fe_pair_sum #(
   parameter int IN_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic            bypass,
   input  logic [IN_W-1:0] sample,
   output logic [IN_W:0]   pair_sum
);

   logic [IN_W-1:0] hist_q;

   // History register: holds the last accepted sample, cleared by reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (take) begin
         hist_q <= sample;
      end
   end

   // Doubling the lone sample puts both modes on the same half-scale grid.
   always_comb begin
      if (bypass) begin
         pair_sum = {sample, 1'b0};
      end else begin
         pair_sum = {sample[IN_W-1], sample} + {hist_q[IN_W-1], hist_q};
      end
   end

endmodule

// File: rtl/fe_tie_round.sv
module fe_tie_round
   import fe_avg_pkg::*;
#(
   parameter int IN_W  = 4,
   parameter int OUT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [IN_W:0]    pair_sum,
   output logic [OUT_W-1:0] code
);

   localparam int SUM_W  = IN_W + 1;
   localparam int WIDE_W = IN_W + 2;
   localparam logic signed [WIDE_W-1:0] CODE_MAX = WIDE_W'((2 ** (OUT_W - 1)) - 1);
   localparam logic signed [WIDE_W-1:0] CODE_MIN = WIDE_W'(-(2 ** (OUT_W - 1)));

   tie_dir_e                  dir_q;
   logic                      is_tie;
   logic                      step_down;
   logic signed [WIDE_W-1:0]  half_w;
   logic signed [WIDE_W-1:0]  raw_c;

   // Even sum: the halved value sits exactly between two levels.
   assign is_tie    = ~pair_sum[0];
   assign step_down = is_tie && (dir_q == TIE_DOWN);

   // Arithmetic floor of sum/2, sign-extended to the working width.
   assign half_w = {{2{pair_sum[SUM_W-1]}}, pair_sum[SUM_W-1:1]};
   assign raw_c  = half_w - {{(WIDE_W-1){1'b0}}, step_down};

   always_comb begin
      if (raw_c > CODE_MAX) begin
         code = CODE_MAX[OUT_W-1:0];
      end else if (raw_c < CODE_MIN) begin
         code = CODE_MIN[OUT_W-1:0];
      end else begin
         code = raw_c[OUT_W-1:0];
      end
   end

   // Tie-direction toggle: advances only on an accepted tie.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= TIE_DOWN;
      end else if (take && is_tie) begin
         dir_q <= tie_next(dir_q);
      end
   end

endmodule

// File: rtl/fe_chan.sv
module fe_chan #(
   parameter int IN_W  = 4,
   parameter int OUT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             bypass,
   input  logic [IN_W-1:0]  sample,
   output logic [OUT_W-1:0] code_q
);

   logic [IN_W:0]    pair_sum;
   logic [OUT_W-1:0] code_d;

   fe_pair_sum #(
      .IN_W (IN_W)
   ) u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .bypass   (bypass),
      .sample   (sample),
      .pair_sum (pair_sum)
   );

   fe_tie_round #(
      .IN_W  (IN_W),
      .OUT_W (OUT_W)
   ) u_round (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .pair_sum (pair_sum),
      .code     (code_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (take) begin
         code_q <= code_d;
      end
   end

endmodule

// File: rtl/fe_chip_avg.sv
module fe_chip_avg
   import fe_avg_pkg::*;
#(
   parameter int IN_W  = 4,
   parameter int OUT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             bypass,
   input  logic [IN_W-1:0]  i_in,
   input  logic [IN_W-1:0]  q_in,
   output logic [OUT_W-1:0] i_code,
   output logic [OUT_W-1:0] q_code,
   output logic             out_valid
);

   // Elaboration-time parameter checks.
   if (OUT_W < 2) begin : g_bad_out_w
      $error("fe_chip_avg: OUT_W must be at least 2");
   end
   if (IN_W < OUT_W) begin : g_bad_in_w
      $error("fe_chip_avg: IN_W must not be smaller than OUT_W");
   end

   logic [IN_W-1:0]  ch_in   [NUM_CH];
   logic [OUT_W-1:0] ch_code [NUM_CH];

   assign ch_in[0] = i_in;
   assign ch_in[1] = q_in;
   assign i_code   = ch_code[0];
   assign q_code   = ch_code[1];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      fe_chan #(
         .IN_W  (IN_W),
         .OUT_W (OUT_W)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .take   (in_valid),
         .bypass (bypass),
         .sample (ch_in[g]),
         .code_q (ch_code[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
      end
   end

endmodule

// File: rtl/fe_chip_avg_chk.sv
module fe_chip_avg_chk #(
   parameter int IN_W  = 4,
   parameter int OUT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             bypass,
   input logic [IN_W-1:0]  i_in,
   input logic [IN_W-1:0]  q_in,
   input logic [OUT_W-1:0] i_code,
   input logic [OUT_W-1:0] q_code,
   input logic             out_valid
);

   localparam int LVL_MAX = (2 ** (OUT_W - 1)) - 1;
   localparam int LVL_MIN = -(2 ** (OUT_W - 1));

   function automatic int clip(input int v);
      if (v > LVL_MAX) return LVL_MAX;
      if (v < LVL_MIN) return LVL_MIN;
      return v;
   endfunction

   // A lone sample x must land on one of the two levels around it.
   function automatic logic lone_ok(input logic [IN_W-1:0] x, input logic [OUT_W-1:0] c);
      int xv;
      int cv;
      xv = int'($signed(x));
      cv = int'($signed(c));
      return (cv == clip(xv - 1)) || (cv == clip(xv));
   endfunction

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(i_code) && $stable(q_code)));

   assert_bypass_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bypass) |=> (lone_ok($past(i_in), i_code) && lone_ok($past(q_in), q_code)));

endmodule

bind fe_chip_avg fe_chip_avg_chk #(
   .IN_W  (IN_W),
   .OUT_W (OUT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .bypass    (bypass),
   .i_in      (i_in),
   .q_in      (q_in),
   .i_code    (i_code),
   .q_code    (q_code),
   .out_valid (out_valid)
);

// File: tb/fe_chip_avg_test.sv
module fe_chip_avg_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       bypass = 1'b0;
   logic [3:0] i_in = 4'd0;
   logic [3:0] q_in = 4'd0;
   logic [2:0] i_code;
   logic [2:0] q_code;
   logic       out_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Reference state, derived from the requirements.
   int prev_i = 0;
   int prev_q = 0;
   bit tog_i  = 1'b0;
   bit tog_q  = 1'b0;
   int last_i = 0;
   int last_q = 0;

   int    exp_i_q [$];
   int    exp_q_q [$];
   string tag_q   [$];

   fe_chip_avg uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .bypass    (bypass),
      .i_in      (i_in),
      .q_in      (q_in),
      .i_code    (i_code),
      .q_code    (q_code),
      .out_valid (out_valid)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Odd sum: exact level; even sum: tie resolved by the toggle; then clip.
   function automatic int level(input int s, inout bit tog);
      int c;
      if (s % 2 != 0) begin
         c = (s - 1) / 2;
      end else begin
         c = tog ? (s / 2) : (s / 2 - 1);
         tog = ~tog;
      end
      if (c > 3) c = 3;
      if (c < -4) c = -4;
      return c;
   endfunction

   task automatic send(input int xi, input int xq, input bit byp, input string req);
      int si;
      int sq;
      @(negedge clk);
      in_valid = 1'b1;
      bypass   = byp;
      i_in     = xi[3:0];
      q_in     = xq[3:0];
      si = byp ? 2 * xi : xi + prev_i;
      sq = byp ? 2 * xq : xq + prev_q;
      prev_i = xi;
      prev_q = xq;
      exp_i_q.push_back(level(si, tog_i));
      exp_q_q.push_back(level(sq, tog_q));
      tag_q.push_back(req);
   endtask

   // Idle cycle with junk on the data and mode inputs.
   task automatic idle(input int xi, input int xq, input bit byp);
      @(negedge clk);
      in_valid = 1'b0;
      bypass   = byp;
      i_in     = xi[3:0];
      q_in     = xq[3:0];
   endtask

   // Monitor: results are due one clock after the driving falling edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (exp_i_q.size() == 0) begin
               check("R1", 1, 0);
            end else begin
               string t;
               int ei;
               int eq;
               ei = exp_i_q.pop_front();
               eq = exp_q_q.pop_front();
               t  = tag_q.pop_front();
               check(t, int'($signed(i_code)), ei);
               check(t, int'($signed(q_code)), eq);
               last_i = ei;
               last_q = eq;
            end
         end else begin
            check("R8", int'($signed(i_code)), last_i);
            check("R8", int'($signed(q_code)), last_q);
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state.
      check("R10", int'(out_valid), 0);
      check("R10", int'(i_code), 0);
      check("R10", int'(q_code), 0);
      rst_n = 1'b1;
      idle(0, 0, 1'b0);

      // R7: first sample summed with zero (odd sums, exact).
      send(3, -3, 1'b0, "R7");
      // R2: odd sums with history.
      send(2, -4, 1'b0, "R2");
      send(-1, 1, 1'b0, "R2");
      send(-6, 4, 1'b0, "R2");
      // R3: consecutive ties alternate down/up per channel.
      send(-2, 2, 1'b0, "R3");
      send(2, 2, 1'b0, "R3");
      send(0, 0, 1'b0, "R3");
      send(2, -2, 1'b0, "R3");
      // R4: saturation at both ends.
      send(7, -8, 1'b0, "R4");
      send(7, -8, 1'b0, "R4");
      send(6, -7, 1'b0, "R4");
      idle(0, 0, 1'b0);
      // R5: bypass, ties always, history still updated.
      send(1, -1, 1'b1, "R5");
      send(1, -1, 1'b1, "R5");
      send(7, -8, 1'b1, "R5");
      send(0, 3, 1'b1, "R5");
      send(3, 0, 1'b0, "R5");
      // R6: junk while not valid must not enter history or toggle.
      send(2, -3, 1'b0, "R6");
      idle(7, 7, 1'b0);
      idle(-8, 5, 1'b1);
      send(1, 2, 1'b0, "R6");
      send(1, 1, 1'b0, "R6");
      // R9: I sees ties while Q sees odd sums.
      send(1, 2, 1'b0, "R9");
      send(1, 1, 1'b0, "R9");
      send(3, 2, 1'b0, "R9");
      send(-3, -3, 1'b0, "R9");
      // R2: sweep all inputs back to back.
      for (int x = -8; x < 8; x++) begin
         send(x, -1 - x, 1'b0, "R2");
      end
      idle(0, 0, 1'b0);
      for (int x = 7; x >= -8; x--) begin
         send(x, x, x[0], "R2");
         if (x % 3 == 0) idle(x, -x, 1'b1);
      end
      repeat (4) idle(0, 0, 1'b0);
      check("R1", exp_i_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule